// File: doc/BRIEF.md
# Rate-Adaptive SPI Flash Master

This block is a byte-oriented SPI master that talks to a serial flash device. A host hands it one transfer at a time through a valid/ready command port. Each transfer is an 8-bit byte or a 24-bit address word, sent or received. The master shifts the bits out on MOSI and in from MISO, most significant bit first. It hands read results back on a one-cycle return strobe. Several transfers can be chained under a single chip select, and the select is released only by an explicit end command.

The serial clock rate is chosen again for every transfer. The inputs to that choice are the speed the host last requested, the transfer width and the direction. For writes the byte value also counts: a write byte of all zeros or all ones keeps MOSI constant, so it may run at the fastest rate. All rates come from an 80 MHz system clock through even integer dividers: 2 gives 40 MHz, 8 gives 10 MHz, 16 gives 5 MHz and 24 gives 3.33 MHz. SPI mode 0 and mode 3 are both supported.

Top module: `rate_spi_master`

## Requirements
- R1: After reset, csN is high, cmdReady is high, rdValid is low and sclk sits at the idle level of the selected mode.
- R2: With a requested speed of 3,333,333 Hz or less, every transfer kind runs with an sclk period of 24 system cycles.
- R3: With a requested speed above 3,333,333 Hz and at most 5,000,000 Hz, 8-bit transfers use a period of 16 cycles and 24-bit transfers use 24 cycles.
- R4: With a requested speed above 5,000,000 Hz and at most 10,000,000 Hz, 8-bit transfers use a period of 8 cycles and 24-bit transfers use 24 cycles.
- R5: Above 10,000,000 Hz, 8-bit reads and 8-bit writes of values other than 0x00 and 0xFF use a period of 8 cycles. 8-bit writes of 0x00 or 0xFF use 2 cycles. 24-bit transfers stay at 24 cycles.
- R6: Until the first speed write after reset, the requested speed is 10,000,000 Hz. A value written with speedWe stays in force for all later transfers until the next write. A write in the same cycle as a command acceptance applies from the next command on.
- R7: modeSel=0 selects mode 0, where sclk idles low. modeSel=1 selects mode 3, where sclk idles high and the first low phase of every byte is two system cycles longer than the others. modeSel may change only while csN is high.
- R8: MOSI carries the word MSB first. A 24-bit word is sent as three bytes, high byte first, all at the 24-bit rate. MOSI never changes while sclk is high during a transfer.
- R9: MISO is sampled in the last system cycle of each low phase. A read finishes with rdValid high for one cycle. rdData holds the received word, with 8-bit results right-aligned and zero-extended.
- R10: When a transfer starts from the deselected state, csN falls one system cycle before the first low phase begins. csN then stays low across chained transfers, and sclk does not move while csN is high.
- R11: Command encoding: cmdKind bit 0 set means read, and cmdKind bit 1 set means 24-bit. cmdEnd=1 raises csN and ignores cmdKind and cmdData. An end command while csN is already high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 80 MHz nominal |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Master can take a command |
| cmdKind | input | 2 | Bit 0 read, bit 1 24-bit width |
| cmdEnd | input | 1 | End command: release chip select |
| cmdData | input | 24 | Write data; bytes use bits 7:0 |
| rdValid | output | 1 | One-cycle strobe with read result |
| rdData | output | 24 | Received word |
| speedWe | input | 1 | Load requested speed |
| speedHz | input | 32 | Requested SPI speed in Hz |
| modeSel | input | 1 | 0 = mode 0, 1 = mode 3 |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| csN | output | 1 | Active-low chip select |

## Verification
Some properties are checked on every cycle: sclk stays still while the device is deselected, MOSI holds steady across every high phase, sclk sits at the idle level whenever the master waits for a command under select, modeSel stays unchanged during a select, and the read strobe lasts one cycle. The bench is the only place that can show the rate choice itself. It measures rising-edge spacing against the expected divider for every speed band, width, direction and data value, and it measures the mode-3 stretch at byte boundaries. It also checks the serial bit order against the command data, the returned read data against the MISO pattern it drove, and the persistence of the speed setting.

// File: rtl/rate_spi_pkg.sv
package rate_spi_pkg;

  typedef struct packed {
    logic load;      // take cmdData into the shifter
    logic sample;    // shift in MISO at end of low phase
    logic advance;   // present next bit on MOSI
    logic finish;    // last high phase done
    logic readXfer;  // current transfer is a read
    logic wideXfer;  // current transfer is 24-bit
  } spi_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SEL,
    ST_LOW,
    ST_HIGH
  } spi_state_t;

endpackage

// File: rtl/rate_spi_speed.sv
module rate_spi_speed #(
  parameter int SPEED_W    = 32,
  parameter int BYTE_W     = 8,
  parameter int DEFAULT_HZ = 10_000_000,
  parameter int LIMIT_SLOW = 3_333_333,
  parameter int LIMIT_MID  = 5_000_000,
  parameter int LIMIT_BYTE = 10_000_000,
  parameter int DIV_FAST   = 2,
  parameter int DIV_BYTE   = 8,
  parameter int DIV_MID    = 16,
  parameter int DIV_SLOW   = 24,
  parameter int HALF_W     = $clog2(DIV_SLOW / 2 + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               speedWe,
  input  logic [SPEED_W-1:0] speedHz,
  input  logic               reqWide,
  input  logic               reqRead,
  input  logic [BYTE_W-1:0]  reqByte,
  output logic [HALF_W-1:0]  halfCycles
);

  localparam logic [HALF_W-1:0] HALF_FAST = HALF_W'(DIV_FAST / 2);
  localparam logic [HALF_W-1:0] HALF_BYTE = HALF_W'(DIV_BYTE / 2);
  localparam logic [HALF_W-1:0] HALF_MID  = HALF_W'(DIV_MID / 2);
  localparam logic [HALF_W-1:0] HALF_SLOW = HALF_W'(DIV_SLOW / 2);

  logic [SPEED_W-1:0] speedQ;
  logic               flatByte;

  always_ff @(posedge clk) begin
    if (!rstN)        speedQ <= SPEED_W'(DEFAULT_HZ);
    else if (speedWe) speedQ <= speedHz;
  end

  assign flatByte = (reqByte == '0) || (reqByte == '1);

  always_comb begin
    if (speedQ <= SPEED_W'(LIMIT_SLOW) || reqWide) halfCycles = HALF_SLOW;
    else if (speedQ <= SPEED_W'(LIMIT_MID))         halfCycles = HALF_MID;
    else if (speedQ <= SPEED_W'(LIMIT_BYTE))        halfCycles = HALF_BYTE;
    else if (!reqRead && flatByte)                  halfCycles = HALF_FAST;
    else                                            halfCycles = HALF_BYTE;
  end

endmodule

// File: rtl/rate_spi_ctrl.sv
module rate_spi_ctrl
  import rate_spi_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int BYTE_W  = 8,
  parameter int HALF_W  = 4,
  parameter int STRETCH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdRead,
  input  logic              cmdWide,
  input  logic              cmdEnd,
  input  logic              modeSel,
  input  logic [HALF_W-1:0] halfIn,
  output logic              sclk,
  output logic              csN,
  output spi_strobe_t       strobes
);

  localparam int CNT_W   = HALF_W + 1;
  localparam int BIT_W   = $clog2(WORD_W);
  localparam int BYTE_LG = $clog2(BYTE_W);

  spi_state_t        stateQ;
  logic [CNT_W-1:0]  cntQ;
  logic [HALF_W-1:0] halfQ;
  logic [BIT_W-1:0]  bitsQ;
  logic              sclkQ, csNQ, readQ, wideQ;

  logic              accept, startXfer, cntZero;
  logic [CNT_W-1:0]  stretchAdd, firstLow, setupLow, highLen, nextLow;

  always_comb begin
    cmdReady   = (stateQ == ST_IDLE) || (stateQ == ST_SEL);
    accept     = cmdValid && cmdReady;
    startXfer  = accept && !cmdEnd;
    cntZero    = (cntQ == '0);
    stretchAdd = modeSel ? CNT_W'(STRETCH) : '0;
    firstLow   = CNT_W'(halfIn) + stretchAdd - CNT_W'(1);
    setupLow   = CNT_W'(halfQ) + stretchAdd - CNT_W'(1);
    highLen    = CNT_W'(halfQ) - CNT_W'(1);
    nextLow    = highLen + ((modeSel && bitsQ[BYTE_LG-1:0] == '0) ? CNT_W'(STRETCH) : '0);

    strobes.load     = startXfer;
    strobes.sample   = (stateQ == ST_LOW) && cntZero;
    strobes.advance  = (stateQ == ST_HIGH) && cntZero && (bitsQ != '0);
    strobes.finish   = (stateQ == ST_HIGH) && cntZero && (bitsQ == '0);
    strobes.readXfer = readQ;
    strobes.wideXfer = wideQ;

    sclk = csNQ ? modeSel : sclkQ;
    csN  = csNQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      halfQ  <= '0;
      bitsQ  <= '0;
      sclkQ  <= 1'b0;
      csNQ   <= 1'b1;
      readQ  <= 1'b0;
      wideQ  <= 1'b0;
    end else begin
      if (startXfer) begin
        halfQ <= halfIn;
        readQ <= cmdRead;
        wideQ <= cmdWide;
        bitsQ <= cmdWide ? BIT_W'(WORD_W - 1) : BIT_W'(BYTE_W - 1);
      end
      unique case (stateQ)
        ST_IDLE: begin
          if (startXfer) begin
            csNQ   <= 1'b0;
            sclkQ  <= modeSel;
            stateQ <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          sclkQ  <= 1'b0;
          cntQ   <= setupLow;
          stateQ <= ST_LOW;
        end
        ST_SEL: begin
          if (accept && cmdEnd) begin
            csNQ   <= 1'b1;
            stateQ <= ST_IDLE;
          end else if (startXfer) begin
            sclkQ  <= 1'b0;
            cntQ   <= firstLow;
            stateQ <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (cntZero) begin
            sclkQ  <= 1'b1;
            cntQ   <= highLen;
            stateQ <= ST_HIGH;
          end else begin
            cntQ <= cntQ - CNT_W'(1);
          end
        end
        ST_HIGH: begin
          if (cntZero) begin
            if (bitsQ == '0) begin
              sclkQ  <= modeSel;
              stateQ <= ST_SEL;
            end else begin
              bitsQ  <= bitsQ - BIT_W'(1);
              sclkQ  <= 1'b0;
              cntQ   <= nextLow;
              stateQ <= ST_LOW;
            end
          end else begin
            cntQ <= cntQ - CNT_W'(1);
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rate_spi_datapath.sv
module rate_spi_datapath
  import rate_spi_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spi_strobe_t       strobes,
  input  logic [WORD_W-1:0] cmdData,
  input  logic              cmdWide,
  input  logic              miso,
  output logic              mosi,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData
);

  localparam int PAD_W = WORD_W - BYTE_W;

  logic [WORD_W-1:0] shQ;
  logic              mosiQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shQ     <= '0;
      mosiQ   <= 1'b0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= 1'b0;
      if (strobes.load) begin
        shQ   <= cmdWide ? cmdData : {cmdData[BYTE_W-1:0], {PAD_W{1'b0}}};
        mosiQ <= cmdWide ? cmdData[WORD_W-1] : cmdData[BYTE_W-1];
      end else if (strobes.sample) begin
        shQ <= {shQ[WORD_W-2:0], miso};
      end else if (strobes.advance) begin
        mosiQ <= shQ[WORD_W-1];
      end
      if (strobes.finish) begin
        rdValid <= strobes.readXfer;
        rdData  <= strobes.wideXfer ? shQ : {{PAD_W{1'b0}}, shQ[BYTE_W-1:0]};
      end
    end
  end

  assign mosi = mosiQ;

endmodule

// File: rtl/rate_spi_master.sv
module rate_spi_master
  import rate_spi_pkg::*;
#(
  parameter int WORD_W     = 24,
  parameter int BYTE_W     = 8,
  parameter int SPEED_W    = 32,
  parameter int DEFAULT_HZ = 10_000_000,
  parameter int DIV_FAST   = 2,
  parameter int DIV_BYTE   = 8,
  parameter int DIV_MID    = 16,
  parameter int DIV_SLOW   = 24,
  parameter int STRETCH    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic [1:0]         cmdKind,
  input  logic               cmdEnd,
  input  logic [WORD_W-1:0]  cmdData,
  output logic               rdValid,
  output logic [WORD_W-1:0]  rdData,
  input  logic               speedWe,
  input  logic [SPEED_W-1:0] speedHz,
  input  logic               modeSel,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic               csN
);

  localparam int HALF_W = $clog2(DIV_SLOW / 2 + 1);

  spi_strobe_t       strobes;
  logic [HALF_W-1:0] halfCycles;

  rate_spi_speed #(
    .SPEED_W(SPEED_W), .BYTE_W(BYTE_W), .DEFAULT_HZ(DEFAULT_HZ),
    .DIV_FAST(DIV_FAST), .DIV_BYTE(DIV_BYTE), .DIV_MID(DIV_MID),
    .DIV_SLOW(DIV_SLOW), .HALF_W(HALF_W)
  ) u_speed (
    .clk(clk), .rstN(rstN), .speedWe(speedWe), .speedHz(speedHz),
    .reqWide(cmdKind[1]), .reqRead(cmdKind[0]), .reqByte(cmdData[BYTE_W-1:0]),
    .halfCycles(halfCycles)
  );

  rate_spi_ctrl #(
    .WORD_W(WORD_W), .BYTE_W(BYTE_W), .HALF_W(HALF_W), .STRETCH(STRETCH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdRead(cmdKind[0]), .cmdWide(cmdKind[1]), .cmdEnd(cmdEnd),
    .modeSel(modeSel), .halfIn(halfCycles), .sclk(sclk), .csN(csN),
    .strobes(strobes)
  );

  rate_spi_datapath #(
    .WORD_W(WORD_W), .BYTE_W(BYTE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdData(cmdData),
    .cmdWide(cmdKind[1]), .miso(miso), .mosi(mosi),
    .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: rtl/rate_spi_checker.sv
module rate_spi_checker (
  input logic clk,
  input logic rstN,
  input logic cmdReady,
  input logic rdValid,
  input logic modeSel,
  input logic sclk,
  input logic mosi,
  input logic csN
);

  // R10: the clock only moves while the device is selected
  p_sclk_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sclk) && $stable(modeSel)) |-> (!csN && !$past(csN)));

  // R8: serial data holds across every high phase
  p_mosi_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && !csN && !$past(csN)) |-> $stable(mosi));

  // R7: waiting under select leaves the clock at the mode's idle level
  p_idle_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady && !csN) |-> (sclk == modeSel));

  // R7: mode held for the whole select
  p_mode_steady_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !$past(csN)) |-> $stable(modeSel));

  // R9: read strobe lasts one cycle
  p_rd_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

bind rate_spi_master rate_spi_checker u_chk (.*);

// File: tb/test_rate_spi_master.sv
module test_rate_spi_master;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdKind = 2'b00;
  logic        cmdEnd = 1'b0;
  logic [23:0] cmdData = '0;
  logic        rdValid;
  logic [23:0] rdData;
  logic        speedWe = 1'b0;
  logic [31:0] speedHz = '0;
  logic        modeSel = 1'b0;
  logic        sclk, mosi, miso, csN;

  int checks = 0, failures = 0;
  bit done = 0;

  int cyc = 0, nRise = 0, curWidth = 8, csFallCyc = 0;
  int riseCyc[24];
  logic mosiBits[24];
  logic prevSclk = 1'b0, prevCs = 1'b1;
  logic [23:0] misoWord = '0;
  logic gotRd = 1'b0;
  logic [23:0] rdSeen = '0;
  int curSpeed = 10_000_000;

  always #2 clk = ~clk;

  assign miso = (nRise < curWidth) ? misoWord[curWidth - 1 - nRise] : 1'b0;

  rate_spi_master i_rate_spi_master (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdKind(cmdKind), .cmdEnd(cmdEnd), .cmdData(cmdData),
    .rdValid(rdValid), .rdData(rdData), .speedWe(speedWe), .speedHz(speedHz),
    .modeSel(modeSel), .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  always @(negedge clk) begin
    cyc++;
    if (!csN && prevCs) csFallCyc = cyc;
    if (!csN && sclk && !prevSclk && nRise < 24) begin
      riseCyc[nRise]  = cyc;
      mosiBits[nRise] = mosi;
      nRise++;
    end
    if (rdValid) begin
      gotRd  = 1'b1;
      rdSeen = rdData;
    end
    prevSclk = sclk;
    prevCs   = csN;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expDiv(input int speed, input logic [1:0] kind,
                                input logic [7:0] b);
    if (speed <= 3_333_333 || kind[1]) return 24;
    if (speed <= 5_000_000) return 16;
    if (speed <= 10_000_000) return 8;
    if (!kind[0] && (b == 8'h00 || b == 8'hFF)) return 2;
    return 8;
  endfunction

  function automatic string rateReq(input int speed);
    if (speed <= 3_333_333) return "R2";
    if (speed <= 5_000_000) return "R3";
    if (speed <= 10_000_000) return "R4";
    return "R5";
  endfunction

  task automatic setSpeed(input int v);
    @(negedge clk);
    speedWe = 1'b1; speedHz = v;
    @(negedge clk);
    speedWe = 1'b0;
    curSpeed = v;
  endtask

  task automatic endSel();
    @(negedge clk);
    cmdValid = 1'b1; cmdEnd = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0; cmdEnd = 1'b0;
    chk(csN == 1'b1, "R10", "csN after end", csN, 1);
    chk(sclk == modeSel, "R7", "idle sclk level", sclk, modeSel);
  endtask

  task automatic xfer(input logic [1:0] kind, input logic [23:0] data,
                      input logic [23:0] mv, input string req);
    int w, d, h, s, bad, gap, eg;
    bit fresh;
    logic [23:0] expRd;
    w = kind[1] ? 24 : 8;
    d = expDiv(curSpeed, kind, data[7:0]);
    h = d / 2;
    s = modeSel ? 2 : 0;
    fresh = csN;
    @(negedge clk);
    nRise = 0; curWidth = w; misoWord = mv; gotRd = 1'b0;
    cmdValid = 1'b1; cmdKind = kind; cmdData = data; cmdEnd = 1'b0;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    chk(nRise == w, "R8", "rising edge count", nRise, w);
    if (fresh)
      chk(riseCyc[0] == csFallCyc + 1 + h + s, "R10", "first rise after select",
          riseCyc[0] - csFallCyc, 1 + h + s);
    bad = 0; gap = 0; eg = 0;
    for (int i = 1; i < w; i++) begin
      int e;
      e = d + ((modeSel && (i % 8 == 0)) ? 2 : 0);
      if (bad == 0 && (riseCyc[i] - riseCyc[i-1]) != e) begin
        bad = 1; gap = riseCyc[i] - riseCyc[i-1]; eg = e;
      end
    end
    chk(bad == 0, modeSel ? "R7" : req, "sclk rise spacing", gap, eg);
    bad = 0;
    for (int i = 0; i < w; i++)
      if (mosiBits[i] !== data[w - 1 - i]) bad = 1;
    chk(bad == 0, "R8", "MOSI bit order", bad, 0);
    chk(csN == 1'b0, "R10", "csN held after transfer", csN, 0);
    if (kind[0]) begin
      expRd = kind[1] ? mv : {16'h0, mv[7:0]};
      chk(gotRd && rdSeen == expRd, "R9", "read data", rdSeen, expRd);
    end else begin
      chk(!gotRd, "R9", "no read strobe on write", gotRd, 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN == 1'b1, "R1", "reset csN", csN, 1);
    chk(cmdReady == 1'b1, "R1", "reset cmdReady", cmdReady, 1);
    chk(rdValid == 1'b0, "R1", "reset rdValid", rdValid, 0);
    chk(sclk == 1'b0, "R1", "reset sclk mode0", sclk, 0);

    // R6: default speed 10 MHz, flat bytes not fast
    xfer(2'b00, 24'h00005A, 24'h0, "R6");
    xfer(2'b00, 24'h000000, 24'h0, "R6");
    xfer(2'b10, 24'hC2A5_3C, 24'h0, "R4");
    xfer(2'b01, 24'h0, 24'h0000B7, "R4");
    endSel();

    // R11: end while deselected has no effect
    endSel();
    chk(nRise == 8, "R11", "no clocks from idle end", nRise, 8);

    setSpeed(3_333_333);
    xfer(2'b00, 24'h0000FF, 24'h0, "R2");
    xfer(2'b01, 24'h0, 24'h00003C, "R2");
    xfer(2'b11, 24'h0, 24'h9A_5E_21, "R2");
    endSel();
    setSpeed(3_333_334);
    xfer(2'b00, 24'h000011, 24'h0, "R3");
    setSpeed(5_000_000);
    xfer(2'b01, 24'h0, 24'h000081, "R3");
    xfer(2'b10, 24'h123456, 24'h0, "R3");
    setSpeed(5_000_001);
    xfer(2'b00, 24'h000000, 24'h0, "R4");
    setSpeed(10_000_000);
    xfer(2'b00, 24'h0000FF, 24'h0, "R4");
    endSel();

    setSpeed(10_000_001);
    xfer(2'b00, 24'h0000FF, 24'h0, "R5");
    xfer(2'b00, 24'h000000, 24'h0, "R5");
    xfer(2'b00, 24'h000001, 24'h0, "R5");
    xfer(2'b00, 24'h0000FE, 24'h0, "R5");
    xfer(2'b01, 24'h0, 24'h0000FF, "R5");
    xfer(2'b11, 24'h0, 24'hFFFFFF, "R5");
    endSel();

    // R7: mode 3 with stretched byte starts
    @(negedge clk);
    modeSel = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1, "R7", "mode3 idle high", sclk, 1);
    xfer(2'b00, 24'h0000A3, 24'h0, "R7");
    xfer(2'b11, 24'h0, 24'h6D_02_F0, "R7");
    xfer(2'b00, 24'h000000, 24'h0, "R7");
    setSpeed(40_000_000);
    xfer(2'b10, 24'hFF00FF, 24'h0, "R7");
    endSel();

    // R6: speed persists
    xfer(2'b00, 24'h0000FF, 24'h0, "R6");
    endSel();
    @(negedge clk);
    modeSel = 1'b0;

    // random mix
    void'($urandom(32'd20240611));
    for (int it = 0; it < 30; it++) begin
      int sp, nx;
      int speeds[8] = '{2_000_000, 3_333_333, 4_000_000, 5_000_000,
                        8_000_000, 10_000_000, 20_000_000, 40_000_000};
      @(negedge clk);
      modeSel = $urandom_range(0, 1);
      sp = speeds[$urandom_range(0, 7)];
      setSpeed(sp);
      nx = $urandom_range(1, 3);
      for (int k = 0; k < nx; k++) begin
        logic [1:0] kd;
        logic [23:0] dt;
        int pick;
        kd = 2'($urandom_range(0, 3));
        dt = 24'($urandom);
        pick = $urandom_range(0, 2);
        if (pick == 0) dt[7:0] = 8'h00;
        else if (pick == 1) dt[7:0] = 8'hFF;
        xfer(kd, dt, 24'($urandom), rateReq(sp));
      end
      endSel();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule